// File: doc/BRIEF.md
# ECC Protected Window Filter

This block sits beside a memory controller's request path and decides, for every access address it is shown, whether inline error correction covers that address. It keeps a small set of programmable windows. Each window has a lower and an upper bound, both inclusive. Bounds count 64 KiB granules from a fixed memory base address. A lookup produces one registered "ECC applies" flag and the index of the window that matched.

Software programs the windows and a control word through a plain register write port, and can read them back through a read port. To take a window out of service for a while, software swaps the window's two bounds so that the lower bound is above the upper bound. Writing the original values back restores the window. Nothing else changes when a window is disabled this way, so no separate enable bit is needed.

The control word holds a global protection enable. It also holds three further configuration flags, which the block drives straight out to the controller.

Top module: `ecc_window_filter`

## Requirements
- R1: After reset the control word reads 0, every lower-bound register reads all ones (0xFFFF), every upper-bound register reads 0, and `ecc_hit` and `hit_idx` are 0.
- R2: Register map. The control word is at offset 0x00. Window i has its lower bound at 0x10+8·i and its upper bound at 0x14+8·i. A bound register keeps the low 16 bits of the written data. `rd_data` shows the register at `rd_addr` one cycle after `rd_addr` is applied. Unmapped offsets read 0.
- R3: In the control word, bit 0 is the global protection enable, bit 1 is read-modify-write enable, bit 2 is check enable and bit 4 is write-allocate. All other bits read 0. The four bits appear on `cfg_ecc_en`, `cfg_rmw_en`, `cfg_chk_en` and `cfg_wr_alloc`.
- R4: The granule of an address is (address − MEM_BASE) >> 16. Window i matches when lower ≤ granule ≤ upper, with both bounds inclusive.
- R5: A window whose lower bound is greater than its upper bound matches no address.
- R6: When several windows match, `hit_idx` reports the lowest-numbered one.
- R7: `ecc_hit` is 1 only if some window matches and the global enable is set. While `ecc_hit` is 0, `hit_idx` is 0.
- R8: An address below MEM_BASE never matches.
- R9: `ecc_hit` and `hit_idx` reflect the address present one cycle earlier. A register write is applied to the lookup in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write byte offset |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | REG_AW | Register read byte offset |
| rd_data | output | DATA_W | Registered read data |
| lk_addr | input | ADDR_W | Access address to classify |
| ecc_hit | output | 1 | Registered "ECC applies" flag |
| hit_idx | output | IDX_W | Lowest matching window, 0 when no hit |
| cfg_ecc_en | output | 1 | Global protection enable |
| cfg_rmw_en | output | 1 | Read-modify-write enable flag |
| cfg_chk_en | output | 1 | Check enable flag |
| cfg_wr_alloc | output | 1 | Write-allocate flag |

## Verification
The bench builds the block with its defaults: three windows, 32-bit addresses and a memory base of 0x8000_0000. With these values the granule field is exactly 16 bits wide, so a window can span granules 0 through 0xFFFF and reach the top of the address space. The address just below the base can be tested for underflow, and the last byte of a granule can be tested as an inclusive upper bound. Three windows are enough to cover both two-way and three-way overlap when checking priority.

// File: rtl/ecc_win_pkg.sv
package ecc_win_pkg;
  localparam int CTRL_OFS      = 'h00;
  localparam int WIN_BASE_OFS  = 'h10;
  localparam int WIN_STRIDE    = 8;
  localparam int WIN_HI_DELTA  = 4;
  localparam int BIT_ECC_EN    = 0;
  localparam int BIT_RMW_EN    = 1;
  localparam int BIT_CHK_EN    = 2;
  localparam int BIT_WR_ALLOC  = 4;
  localparam int GRAN_SHIFT    = 16;

  function automatic int lo_ofs(input int idx);
    return WIN_BASE_OFS + WIN_STRIDE * idx;
  endfunction

  function automatic int hi_ofs(input int idx);
    return WIN_BASE_OFS + WIN_STRIDE * idx + WIN_HI_DELTA;
  endfunction
endpackage

// File: rtl/ecc_win_regs.sv
module ecc_win_regs #(
  parameter int NUM_WIN = 3,
  parameter int REG_AW  = 8,
  parameter int DATA_W  = 32,
  parameter int BOUND_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [REG_AW-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [4:0]           ctrl,
  output logic [BOUND_W-1:0]   lo_b [NUM_WIN],
  output logic [BOUND_W-1:0]   hi_b [NUM_WIN]
);
  import ecc_win_pkg::*;

  localparam logic [4:0] CTRL_MASK = 5'b10111;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_b[i] <= '1;
        hi_b[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(CTRL_OFS))
        ctrl <= wr_data[4:0] & CTRL_MASK;
      for (int i = 0; i < NUM_WIN; i++) begin
        if (wr_addr == REG_AW'(lo_ofs(i))) lo_b[i] <= wr_data[BOUND_W-1:0];
        if (wr_addr == REG_AW'(hi_ofs(i))) hi_b[i] <= wr_data[BOUND_W-1:0];
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr == REG_AW'(CTRL_OFS))
      rd_mux = {{(DATA_W-5){1'b0}}, ctrl};
    for (int i = 0; i < NUM_WIN; i++) begin
      if (rd_addr == REG_AW'(lo_ofs(i))) rd_mux = {{(DATA_W-BOUND_W){1'b0}}, lo_b[i]};
      if (rd_addr == REG_AW'(hi_ofs(i))) rd_mux = {{(DATA_W-BOUND_W){1'b0}}, hi_b[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/ecc_win_cmp.sv
module ecc_win_cmp #(
  parameter int BOUND_W = 16
) (
  input  logic               below_base,
  input  logic [BOUND_W-1:0] gran,
  input  logic [BOUND_W-1:0] lo,
  input  logic [BOUND_W-1:0] hi,
  output logic               match
);
  assign match = !below_base && (gran >= lo) && (gran <= hi);
endmodule

// File: rtl/ecc_win_prio.sv
module ecc_win_prio #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end
  assign any = |req;
endmodule

// File: rtl/ecc_window_filter.sv
module ecc_window_filter #(
  parameter int          NUM_WIN  = 3,
  parameter int          ADDR_W   = 32,
  parameter int          REG_AW   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  localparam int         BOUND_W  = ADDR_W - ecc_win_pkg::GRAN_SHIFT,
  localparam int         IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              ecc_hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              cfg_ecc_en,
  output logic              cfg_rmw_en,
  output logic              cfg_chk_en,
  output logic              cfg_wr_alloc
);
  import ecc_win_pkg::*;

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MEM_BASE);

  logic [4:0]         ctrl;
  logic [BOUND_W-1:0] lo_b [NUM_WIN];
  logic [BOUND_W-1:0] hi_b [NUM_WIN];

  ecc_win_regs #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .DATA_W(DATA_W), .BOUND_W(BOUND_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl), .lo_b(lo_b), .hi_b(hi_b)
  );

  logic [ADDR_W-1:0]  offset;
  logic [BOUND_W-1:0] gran;
  logic               below;
  assign below  = lk_addr < BASE;
  assign offset = lk_addr - BASE;
  assign gran   = offset[ADDR_W-1:GRAN_SHIFT];

  logic [NUM_WIN-1:0] match;
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    ecc_win_cmp #(.BOUND_W(BOUND_W)) u_cmp (
      .below_base(below), .gran(gran), .lo(lo_b[g]), .hi(hi_b[g]), .match(match[g])
    );
  end

  logic             any_match;
  logic [IDX_W-1:0] first_idx;
  ecc_win_prio #(.N(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .req(match), .any(any_match), .idx(first_idx)
  );

  logic hit_d;
  assign hit_d = any_match && ctrl[BIT_ECC_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_hit <= 1'b0;
      hit_idx <= '0;
    end else begin
      ecc_hit <= hit_d;
      hit_idx <= hit_d ? first_idx : '0;
    end
  end

  assign cfg_ecc_en   = ctrl[BIT_ECC_EN];
  assign cfg_rmw_en   = ctrl[BIT_RMW_EN];
  assign cfg_chk_en   = ctrl[BIT_CHK_EN];
  assign cfg_wr_alloc = ctrl[BIT_WR_ALLOC];
endmodule

// File: rtl/ecc_window_filter_chk.sv
module ecc_window_filter_chk #(
  parameter int          NUM_WIN  = 3,
  parameter int          ADDR_W   = 32,
  parameter int          REG_AW   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000,
  parameter int          IDX_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              ecc_hit,
  input logic [IDX_W-1:0]  hit_idx,
  input logic              cfg_ecc_en
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MEM_BASE);

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ecc_hit |-> $past(cfg_ecc_en)); // R7

  AST_IDX_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !ecc_hit |-> hit_idx == '0); // R7

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ecc_hit |-> int'(hit_idx) < NUM_WIN); // R6

  AST_BELOW_BASE_MISS: assert property (@(posedge clk) disable iff (rst)
    $past(lk_addr) < BASE |-> !ecc_hit); // R8

  AST_CTRL_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == REG_AW'(ecc_win_pkg::CTRL_OFS)) |->
      cfg_ecc_en == $past(wr_data[0])); // R9
endmodule

bind ecc_window_filter ecc_window_filter_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DATA_W(DATA_W),
  .MEM_BASE(MEM_BASE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .lk_addr(lk_addr), .ecc_hit(ecc_hit), .hit_idx(hit_idx), .cfg_ecc_en(cfg_ecc_en)
);

// File: tb/test_ecc_window_filter.sv
`timescale 1ns/1ps
module test_ecc_window_filter;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] lk_addr = '0;
  logic        ecc_hit;
  logic [1:0]  hit_idx;
  logic        cfg_ecc_en, cfg_rmw_en, cfg_chk_en, cfg_wr_alloc;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ecc_window_filter i_ecc_window_filter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_addr(lk_addr),
    .ecc_hit(ecc_hit), .hit_idx(hit_idx), .cfg_ecc_en(cfg_ecc_en),
    .cfg_rmw_en(cfg_rmw_en), .cfg_chk_en(cfg_chk_en), .cfg_wr_alloc(cfg_wr_alloc)
  );

  function automatic logic [31:0] gaddr(input logic [31:0] g);
    return BASE + (g << 16);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(req, rd_data, exp);
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic h, input logic [1:0] i);
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    check({req, " hit"}, 32'(ecc_hit), 32'(h));
    check({req, " idx"}, 32'(hit_idx), 32'(i));
  endtask

  task automatic set_win(input int w, input logic [15:0] lo, input logic [15:0] hi);
    reg_wr(8'(8'h10 + 8 * w), 32'(lo));
    reg_wr(8'(8'h14 + 8 * w), 32'(hi));
  endtask

  task automatic t_reset;
    check("R1 hit after reset", 32'(ecc_hit), 0);
    check("R1 idx after reset", 32'(hit_idx), 0);
    reg_rd("R1 ctrl reset", 8'h00, 32'h0);
    reg_rd("R1 lo0 reset", 8'h10, 32'hFFFF);
    reg_rd("R1 hi2 reset", 8'h24, 32'h0);
    reg_wr(8'h00, 32'h1);
    look("R1 reset windows empty", gaddr(0), 1'b0, 2'd0);
  endtask

  task automatic t_regmap;
    reg_wr(8'h00, 32'hFFFF_FFFF);
    reg_rd("R3 ctrl reserved bits", 8'h00, 32'h17);
    check("R3 cfg outputs", {28'h0, cfg_wr_alloc, cfg_chk_en, cfg_rmw_en, cfg_ecc_en}, 32'hF);
    reg_wr(8'h00, 32'h4);
    check("R3 cfg chk only", {28'h0, cfg_wr_alloc, cfg_chk_en, cfg_rmw_en, cfg_ecc_en}, 32'h4);
    reg_wr(8'h18, 32'h0001_2345);
    reg_rd("R2 lo1 low 16 bits", 8'h18, 32'h2345);
    reg_rd("R2 lo0 untouched", 8'h10, 32'hFFFF);
    reg_rd("R2 unmapped reads 0", 8'h0C, 32'h0);
    reg_wr(8'h18, 32'hFFFF);
  endtask

  task automatic t_bounds;
    reg_wr(8'h00, 32'h1);
    set_win(0, 16'h10, 16'h20);
    look("R4 below lo", gaddr(32'h0F) + 32'hFFFF, 1'b0, 2'd0);
    look("R4 lo inclusive", gaddr(32'h10), 1'b1, 2'd0);
    look("R4 hi inclusive", gaddr(32'h20) + 32'hFFFF, 1'b1, 2'd0);
    look("R4 above hi", gaddr(32'h21), 1'b0, 2'd0);
  endtask

  task automatic t_swap;
    set_win(0, 16'h20, 16'h10);
    look("R5 swapped bounds", gaddr(32'h15), 1'b0, 2'd0);
    look("R5 swapped at edge", gaddr(32'h10), 1'b0, 2'd0);
    set_win(0, 16'h10, 16'h20);
    look("R5 restored", gaddr(32'h15), 1'b1, 2'd0);
    set_win(0, 16'hFFFF, 16'h0);
  endtask

  task automatic t_overlap;
    set_win(1, 16'h100, 16'h200);
    set_win(2, 16'h180, 16'h300);
    look("R6 only w2", gaddr(32'h250), 1'b1, 2'd2);
    look("R6 w1 beats w2", gaddr(32'h190), 1'b1, 2'd1);
    set_win(0, 16'h150, 16'h1A0);
    look("R6 w0 beats all", gaddr(32'h190), 1'b1, 2'd0);
  endtask

  task automatic t_global;
    reg_wr(8'h00, 32'h16);
    look("R7 global off", gaddr(32'h190), 1'b0, 2'd0);
    reg_wr(8'h00, 32'h1);
    look("R7 global on", gaddr(32'h190), 1'b1, 2'd0);
  endtask

  task automatic t_below;
    set_win(0, 16'h0, 16'hFFFF);
    look("R8 below base", BASE - 32'h1, 1'b0, 2'd0);
    look("R8 zero address", 32'h0, 1'b0, 2'd0);
    look("R8 at base", BASE, 1'b1, 2'd0);
    look("R8 top of space", 32'hFFFF_FFFF, 1'b1, 2'd0);
  endtask

  task automatic t_timing;
    set_win(0, 16'hFFFF, 16'h0);
    set_win(1, 16'hFFFF, 16'h0);
    set_win(2, 16'hFFFF, 16'h0);
    @(negedge clk);
    lk_addr = gaddr(32'h40);
    @(negedge clk);
    check("R9 no window yet", 32'(ecc_hit), 0);
    wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'h40;
    @(negedge clk);
    wr_addr = 8'h24;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 hit not before write applies", 32'(ecc_hit), 0);
    @(negedge clk);
    check("R9 hit the cycle after write", 32'(ecc_hit), 1);
    check("R9 idx after write", 32'(hit_idx), 2);
    lk_addr = gaddr(32'h41);
    #2;
    check("R9 output held until edge", 32'(ecc_hit), 1);
    @(negedge clk);
    check("R9 output after edge", 32'(ecc_hit), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_bounds();
    t_swap();
    t_overlap();
    t_global();
    t_below();
    t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule